// File: doc/BRIEF.md
# Control Endpoint Buffer Ownership Controller

This block arbitrates a single packet buffer of a USB default control endpoint between a CPU register interface and a serial interface engine (SIE). A direction input selects host-to-device (control write) or device-to-host (control read) handling. One valid bit records who owns the buffer, and its meaning flips with the direction.

In control write, the SIE fills the buffer and ends the packet. The valid bit then rises and hands the buffer to the CPU, which drains it byte by byte. In control read, the CPU fills the buffer. The valid bit rises when the packet is full or when the CPU forces it. The SIE then reads the bytes out and reports that the packet went out.

A clear command flushes data. Forcing valid on a partly filled or empty buffer marks a short or zero-length packet for the SIE. Two sticky interrupt flags signal buffer-ready and buffer-empty. The packet memory is a small register file inside the block.

Top module: `ep0_buf_ctrl`

## Requirements
- R1: After reset, valid_o, len_o, tx_short_o, tx_zlp_o, irq_rdy_o and irq_emp_o are all 0, and the mode is control write.
- R2: In control write (dir_rd_i = 0) with valid at 0, each sie_rx_we_i stores one byte. Bytes past the 8-byte maximum packet size are dropped. sie_rx_done_i sets valid to 1, and len_o then shows the stored count (including a byte accepted in that cycle). The same event sets irq_rdy_o. While valid is 1, SIE writes and done pulses have no effect.
- R3: In control write with valid at 1, buf_rdata_o shows the next unread byte, in arrival order. Each cpu_pop_i advances to the next byte. When the last byte is popped, valid and len_o return to 0.
- R4: In control write, a control write with ctl_clr_i = 1 while valid is 1 sets valid and len_o to 0. While valid is 0, the clear and the valid-set bit are ignored, and bytes the SIE has already stored are kept.
- R5: In control read (dir_rd_i = 1) with valid at 0, each cpu_push_i stores one byte. The eighth byte sets valid to 1 with tx_short_o at 0. A push is ignored while valid is 1, and it is ignored in any cycle that carries an accepted control write.
- R6: In control read, a control write with ctl_set_i = 1 while valid is 0 sets valid to 1 and leaves len_o at the bytes held. tx_short_o is 1 when that count is below 8. tx_zlp_o is 1 when the count is 0.
- R7: In control read with valid at 0, a control write with ctl_set_i = 1 and ctl_clr_i = 1 together first empties the buffer and then sets valid. The result is valid 1, len_o 0 and tx_zlp_o 1. Valid returns to 0 only when the packet has been sent or cleared.
- R8: In control read, a clear while valid is 0 empties the CPU data (len_o to 0, valid stays 0). A clear while valid is 1 empties the SIE data and sets valid to 0.
- R9: In control read with valid at 1, buf_rdata_o shows the next byte to send. sie_tx_rd_i advances it, and sie_tx_start_i rewinds it to the first byte. sie_tx_done_i sets valid and len_o to 0.
- R10: In control read, whenever valid falls from 1 to 0 (packet sent or cleared) while emp_en_i is 1, irq_emp_o is set.
- R11: While req_pend_i is 1, control writes (ctl_we_i) have no effect.
- R12: The interrupt flags are sticky. irq_rdy_clr_i and irq_emp_clr_i clear them. When a set event and a clear fall in the same cycle, the flag ends at 1.
- R13: A change of dir_rd_i flushes the buffer in the next clock edge (valid 0, len_o 0) without setting any interrupt. The new mode applies from the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_rd_i | input | 1 | 1 = control read, 0 = control write |
| req_pend_i | input | 1 | Endpoint request pending; blocks control writes |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_set_i | input | 1 | Valid bit value written |
| ctl_clr_i | input | 1 | Clear bit value written |
| emp_en_i | input | 1 | Buffer-empty interrupt enable |
| irq_rdy_clr_i | input | 1 | Clear buffer-ready flag |
| irq_emp_clr_i | input | 1 | Clear buffer-empty flag |
| cpu_push_i | input | 1 | CPU writes one byte |
| cpu_wdata_i | input | 8 | CPU write byte |
| cpu_pop_i | input | 1 | CPU consumes one byte |
| sie_rx_we_i | input | 1 | SIE received byte strobe |
| sie_rx_data_i | input | 8 | SIE received byte |
| sie_rx_done_i | input | 1 | SIE packet receive complete |
| sie_tx_start_i | input | 1 | SIE starts (or restarts) a transmit |
| sie_tx_rd_i | input | 1 | SIE consumes one byte for transmit |
| sie_tx_done_i | input | 1 | SIE packet transmit complete |
| valid_o | output | 1 | Ownership valid bit |
| len_o | output | 4 | Bytes held in the buffer |
| buf_rdata_o | output | 8 | Byte at the read pointer |
| tx_short_o | output | 1 | Control read packet ready and shorter than maximum |
| tx_zlp_o | output | 1 | Control read packet ready with zero length |
| irq_rdy_o | output | 1 | Buffer-ready interrupt flag |
| irq_emp_o | output | 1 | Buffer-empty interrupt flag |

## Verification
The hardest case to reach is a control read in which valid is forced with set and clear together on a partly filled buffer. The stimulus first pushes four bytes, then issues the combined command, and checks that the zero-length packet survives until the SIE reports it sent. Other races are reached by firing two events in one cycle from the bench tasks: the last pop against a clear, a receive-done against a flag clear, and a push against a control write. A direction change while the buffer is held by the CPU exercises the flush path. A pending request held across set and clear writes exercises the lock-out path.

// File: rtl/ep0_pkg.sv
package ep0_pkg;
  parameter int unsigned MPS_DEF = 8;
  parameter int unsigned DW_DEF  = 8;
  parameter int unsigned NIRQ    = 2;
  typedef enum int unsigned {
    IRQ_RDY = 0,
    IRQ_EMP = 1
  } irq_idx_e;
endpackage

// File: rtl/ep0_buf_mem.sv
module ep0_buf_mem #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk_i) begin
      if (we_i && (waddr_i == AW'(g))) mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ep0_ptr.sv
module ep0_ptr #(
  parameter int unsigned MPS = 8,
  localparam int unsigned CW = $clog2(MPS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          wr_inc_i,
  input  logic          rd_inc_i,
  input  logic          rd_rst_i,
  output logic [CW-1:0] wptr_o,
  output logic [CW-1:0] rptr_o
);
  logic [CW-1:0] wptr_q, rptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (wr_inc_i) wptr_q <= wptr_q + CW'(1);
      if (rd_rst_i)      rptr_q <= '0;
      else if (rd_inc_i) rptr_q <= rptr_q + CW'(1);
    end
  end

  assign wptr_o = wptr_q;
  assign rptr_o = rptr_q;

  a_r2_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wptr_q <= CW'(MPS));
  a_r3_rptr_le_wptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rptr_q <= wptr_q);
endmodule

// File: rtl/ep0_irq.sv
module ep0_irq #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q[g] <= 1'b0;
      else if (set_i[g])  flag_q[g] <= 1'b1;  // set wins
      else if (clr_i[g])  flag_q[g] <= 1'b0;
    end

    a_r12_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_q[g]);
    a_r12_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !flag_q[g]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ep0_own.sv
module ep0_own #(
  parameter int unsigned MPS = 8,
  localparam int unsigned CW = $clog2(MPS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dir_i,
  input  logic          req_i,
  input  logic          ctl_we_i,
  input  logic          ctl_set_i,
  input  logic          ctl_clr_i,
  input  logic          emp_en_i,
  input  logic          cpu_push_i,
  input  logic          cpu_pop_i,
  input  logic          sie_rx_we_i,
  input  logic          sie_rx_done_i,
  input  logic          sie_tx_start_i,
  input  logic          sie_tx_rd_i,
  input  logic          sie_tx_done_i,
  input  logic [CW-1:0] wptr_i,
  input  logic [CW-1:0] rptr_i,
  output logic          valid_o,
  output logic          mode_rd_o,
  output logic          wr_inc_o,
  output logic          rd_inc_o,
  output logic          rd_rst_o,
  output logic          flush_o,
  output logic          rdy_set_o,
  output logic          emp_set_o
);
  logic dir_q, valid_q, valid_d;
  logic dir_chg, wm, rm, ctl, room, unread;
  logic rx_acc, rx_fin, pop_acc, last_pop, wm_clr;
  logic push_acc, push_fill, set_cmd, cpu_clr, sie_clr, tx_fin, rm_fall;
  logic tx_rst, tx_acc;

  assign dir_chg = dir_i ^ dir_q;
  assign wm      = ~dir_q & ~dir_chg;
  assign rm      =  dir_q & ~dir_chg;
  assign ctl     = ctl_we_i & ~req_i;
  assign room    = wptr_i < CW'(MPS);
  assign unread  = rptr_i < wptr_i;

  // control write: SIE fills, CPU drains
  assign rx_acc   = wm & ~valid_q & sie_rx_we_i & room;
  assign rx_fin   = wm & ~valid_q & sie_rx_done_i;
  assign pop_acc  = wm & valid_q & cpu_pop_i & unread;
  assign last_pop = pop_acc & ((rptr_i + CW'(1)) == wptr_i);
  assign wm_clr   = wm & valid_q & ctl & ctl_clr_i;

  // control read: CPU fills, SIE drains
  assign push_acc  = rm & ~valid_q & ~ctl & cpu_push_i & room;
  assign push_fill = push_acc & (wptr_i == CW'(MPS - 1));
  assign set_cmd   = rm & ~valid_q & ctl & ctl_set_i;
  assign cpu_clr   = rm & ~valid_q & ctl & ctl_clr_i;
  assign sie_clr   = rm & valid_q & ctl & ctl_clr_i;
  assign tx_fin    = rm & valid_q & sie_tx_done_i;
  assign rm_fall   = sie_clr | tx_fin;
  assign tx_rst    = rm & valid_q & ~rm_fall & sie_tx_start_i;
  assign tx_acc    = rm & valid_q & ~rm_fall & ~sie_tx_start_i & sie_tx_rd_i & unread;

  always_comb begin
    valid_d = valid_q;
    if (dir_chg)                             valid_d = 1'b0;
    else if (rx_fin | push_fill | set_cmd)   valid_d = 1'b1;
    else if (last_pop | wm_clr | rm_fall)    valid_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      dir_q   <= dir_i;
      valid_q <= valid_d;
    end
  end

  assign valid_o   = valid_q;
  assign mode_rd_o = dir_q;
  assign wr_inc_o  = rx_acc | push_acc;
  assign rd_inc_o  = pop_acc | tx_acc;
  assign rd_rst_o  = tx_rst;
  assign flush_o   = dir_chg | last_pop | wm_clr | rm_fall | cpu_clr;
  assign rdy_set_o = rx_fin;
  assign emp_set_o = rm_fall & emp_en_i;

  a_r2_done_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_fin |=> valid_q);
  a_r7_zlp_after_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_cmd && ctl_clr_i) |=> (valid_q && wptr_i == '0));
  a_r11_req_blocks_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && rm && !valid_q && !cpu_push_i) |=> !valid_q);
  a_r13_dir_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_chg |=> (!valid_q && wptr_i == '0));
  a_r3_last_pop_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_pop |=> (!valid_q && wptr_i == '0));
endmodule

// File: rtl/ep0_buf_ctrl.sv
module ep0_buf_ctrl #(
  parameter int unsigned MPS = ep0_pkg::MPS_DEF,
  parameter int unsigned DW  = ep0_pkg::DW_DEF,
  localparam int unsigned CW = $clog2(MPS + 1),
  localparam int unsigned AW = (MPS > 1) ? $clog2(MPS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dir_rd_i,
  input  logic          req_pend_i,
  input  logic          ctl_we_i,
  input  logic          ctl_set_i,
  input  logic          ctl_clr_i,
  input  logic          emp_en_i,
  input  logic          irq_rdy_clr_i,
  input  logic          irq_emp_clr_i,
  input  logic          cpu_push_i,
  input  logic [DW-1:0] cpu_wdata_i,
  input  logic          cpu_pop_i,
  input  logic          sie_rx_we_i,
  input  logic [DW-1:0] sie_rx_data_i,
  input  logic          sie_rx_done_i,
  input  logic          sie_tx_start_i,
  input  logic          sie_tx_rd_i,
  input  logic          sie_tx_done_i,
  output logic          valid_o,
  output logic [CW-1:0] len_o,
  output logic [DW-1:0] buf_rdata_o,
  output logic          tx_short_o,
  output logic          tx_zlp_o,
  output logic          irq_rdy_o,
  output logic          irq_emp_o
);
  import ep0_pkg::*;

  logic [CW-1:0] wptr, rptr;
  logic valid, mode_rd, wr_inc, rd_inc, rd_rst, flush, rdy_set, emp_set;
  logic [NIRQ-1:0] irq_set, irq_clr, irq_flag;

  ep0_own #(.MPS(MPS)) u_own (
    .clk_i, .rst_ni,
    .dir_i(dir_rd_i), .req_i(req_pend_i),
    .ctl_we_i, .ctl_set_i, .ctl_clr_i, .emp_en_i,
    .cpu_push_i, .cpu_pop_i,
    .sie_rx_we_i, .sie_rx_done_i, .sie_tx_start_i, .sie_tx_rd_i, .sie_tx_done_i,
    .wptr_i(wptr), .rptr_i(rptr),
    .valid_o(valid), .mode_rd_o(mode_rd),
    .wr_inc_o(wr_inc), .rd_inc_o(rd_inc), .rd_rst_o(rd_rst), .flush_o(flush),
    .rdy_set_o(rdy_set), .emp_set_o(emp_set)
  );

  ep0_ptr #(.MPS(MPS)) u_ptr (
    .clk_i, .rst_ni,
    .flush_i(flush), .wr_inc_i(wr_inc), .rd_inc_i(rd_inc), .rd_rst_i(rd_rst),
    .wptr_o(wptr), .rptr_o(rptr)
  );

  ep0_buf_mem #(.DEPTH(MPS), .DW(DW)) u_mem (
    .clk_i,
    .we_i(wr_inc),
    .waddr_i(wptr[AW-1:0]),
    .wdata_i(mode_rd ? cpu_wdata_i : sie_rx_data_i),
    .raddr_i(rptr[AW-1:0]),
    .rdata_o(buf_rdata_o)
  );

  always_comb begin
    irq_set = '0;
    irq_clr = '0;
    irq_set[IRQ_RDY] = rdy_set;
    irq_set[IRQ_EMP] = emp_set;
    irq_clr[IRQ_RDY] = irq_rdy_clr_i;
    irq_clr[IRQ_EMP] = irq_emp_clr_i;
  end

  ep0_irq #(.N(NIRQ)) u_irq (
    .clk_i, .rst_ni, .set_i(irq_set), .clr_i(irq_clr), .flag_o(irq_flag)
  );

  assign valid_o    = valid;
  assign len_o      = wptr;
  assign tx_short_o = mode_rd & valid & (wptr < CW'(MPS));
  assign tx_zlp_o   = mode_rd & valid & (wptr == '0);
  assign irq_rdy_o  = irq_flag[IRQ_RDY];
  assign irq_emp_o  = irq_flag[IRQ_EMP];

  a_r10_emp_on_sent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_rd && dir_rd_i && valid && sie_tx_done_i && emp_en_i) |=> irq_emp_o);
  a_r5_full_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_rd && dir_rd_i && !valid && wr_inc && wptr == CW'(MPS - 1)) |=> (valid_o && !tx_short_o));
endmodule

// File: tb/ep0_buf_ctrl_tb_top.sv
`timescale 1ns/1ps
module ep0_buf_ctrl_tb_top;
  localparam int MPS = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dir = 0, req = 0, ctl_we = 0, ctl_set = 0, ctl_clr = 0, emp_en = 0;
  logic clr_rdy = 0, clr_emp = 0, push = 0, pop = 0;
  logic [7:0] wdata = 0, rxdata = 0;
  logic rx_we = 0, rx_done = 0, tx_start = 0, tx_rd = 0, tx_done = 0;
  logic valid_o, tx_short_o, tx_zlp_o, irq_rdy_o, irq_emp_o;
  logic [3:0] len_o;
  logic [7:0] rdata_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ep0_buf_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dir_rd_i(dir), .req_pend_i(req),
    .ctl_we_i(ctl_we), .ctl_set_i(ctl_set), .ctl_clr_i(ctl_clr), .emp_en_i(emp_en),
    .irq_rdy_clr_i(clr_rdy), .irq_emp_clr_i(clr_emp),
    .cpu_push_i(push), .cpu_wdata_i(wdata), .cpu_pop_i(pop),
    .sie_rx_we_i(rx_we), .sie_rx_data_i(rxdata), .sie_rx_done_i(rx_done),
    .sie_tx_start_i(tx_start), .sie_tx_rd_i(tx_rd), .sie_tx_done_i(tx_done),
    .valid_o(valid_o), .len_o(len_o), .buf_rdata_o(rdata_o),
    .tx_short_o(tx_short_o), .tx_zlp_o(tx_zlp_o),
    .irq_rdy_o(irq_rdy_o), .irq_emp_o(irq_emp_o)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // reference model
  bit m_dir, m_valid, m_rdy, m_emp;
  int q[$];
  int m_ridx;
  bit c, v0, fin, s_r, s_e;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 0; m_valid = 0; q.delete(); m_ridx = 0; m_rdy = 0; m_emp = 0;
    end else begin
      c = ctl_we && !req; v0 = m_valid; fin = 0; s_r = 0; s_e = 0;
      if (dir != m_dir) begin
        m_dir = dir; m_valid = 0; q.delete(); m_ridx = 0;
      end else if (!m_dir) begin
        if (!v0) begin
          if (rx_we && q.size() < MPS) q.push_back(int'(rxdata));
          if (rx_done) begin m_valid = 1; s_r = 1; end
        end else begin
          if (pop && m_ridx < q.size()) begin
            m_ridx++;
            if (m_ridx == q.size()) fin = 1;
          end
          if (c && ctl_clr) fin = 1;
          if (fin) begin m_valid = 0; q.delete(); m_ridx = 0; end
        end
      end else begin
        if (!v0) begin
          if (c) begin
            if (ctl_clr) q.delete();
            if (ctl_set) m_valid = 1;
          end else if (push && q.size() < MPS) begin
            q.push_back(int'(wdata));
            if (q.size() == MPS) m_valid = 1;
          end
        end else begin
          if ((c && ctl_clr) || tx_done) begin
            m_valid = 0; q.delete(); m_ridx = 0; s_e = emp_en;
          end else if (tx_start) m_ridx = 0;
          else if (tx_rd && m_ridx < q.size()) m_ridx++;
        end
      end
      m_rdy = s_r ? 1'b1 : (clr_rdy ? 1'b0 : m_rdy);
      m_emp = s_e ? 1'b1 : (clr_emp ? 1'b0 : m_emp);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      check("R2 valid_o", int'(valid_o), int'(m_valid));
      check("R3 len_o", int'(len_o), q.size());
      if (m_valid && m_ridx < q.size())
        check(m_dir ? "R9 tx byte" : "R3 rx byte", int'(rdata_o), q[m_ridx]);
      check("R6 tx_short_o", int'(tx_short_o), int'(m_dir && m_valid && q.size() < MPS));
      check("R6 tx_zlp_o", int'(tx_zlp_o), int'(m_dir && m_valid && q.size() == 0));
      check("R2 irq_rdy_o", int'(irq_rdy_o), int'(m_rdy));
      check("R10 irq_emp_o", int'(irq_emp_o), int'(m_emp));
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired, all requirements unfinished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic sie_rx(int n, int base, bit fin_pkt);
    for (int i = 0; i < n; i++) begin
      rx_we = 1; rxdata = 8'(base + i); tick();
    end
    rx_we = 0;
    if (fin_pkt) begin rx_done = 1; tick(); rx_done = 0; end
  endtask

  task automatic cpu_pop(int n);
    for (int i = 0; i < n; i++) begin pop = 1; tick(); end
    pop = 0;
  endtask

  task automatic cpu_push(int n, int base);
    for (int i = 0; i < n; i++) begin
      push = 1; wdata = 8'(base + i); tick();
    end
    push = 0;
  endtask

  task automatic ctl(bit s, bit cl);
    ctl_we = 1; ctl_set = s; ctl_clr = cl; tick();
    ctl_we = 0; ctl_set = 0; ctl_clr = 0;
  endtask

  task automatic sie_tx(int n, bit fin_pkt);
    for (int i = 0; i < n; i++) begin tx_rd = 1; tick(); end
    tx_rd = 0;
    if (fin_pkt) begin tx_done = 1; tick(); tx_done = 0; end
  endtask

  initial begin
    tick(2);
    // R1 reset state
    check("R1 valid", int'(valid_o), 0);
    check("R1 len", int'(len_o), 0);
    check("R1 irqs", int'({irq_rdy_o, irq_emp_o, tx_short_o, tx_zlp_o}), 0);
    rst_n = 1; tick(2);

    // R2/R3 receive and drain
    sie_rx(5, 8'h10, 1);
    check("R2 valid after done", int'(valid_o), 1);
    check("R2 len", int'(len_o), 5);
    check("R2 irq_rdy", int'(irq_rdy_o), 1);
    check("R3 first byte", int'(rdata_o), 8'h10);
    cpu_pop(5); tick();
    check("R3 valid freed", int'(valid_o), 0);
    check("R3 len zero", int'(len_o), 0);

    // R2 overflow and ignore while owned by CPU
    sie_rx(10, 8'h20, 1);
    check("R2 len capped", int'(len_o), 8);
    sie_rx(2, 8'h40, 1);
    check("R2 rx ignored when valid", int'(len_o), 8);
    cpu_pop(3);
    ctl(0, 1);
    check("R4 clear valid", int'(valid_o), 0);
    check("R4 clear len", int'(len_o), 0);

    // R4 clear ignored while valid 0
    sie_rx(2, 8'h50, 0);
    ctl(1, 1);
    check("R4 clear ignored", int'(len_o), 2);
    check("R4 set ignored", int'(valid_o), 0);
    // R12 set wins against clear
    rx_done = 1; clr_rdy = 1; tick(); rx_done = 0; clr_rdy = 0;
    check("R12 set wins", int'(irq_rdy_o), 1);
    clr_rdy = 1; tick(); clr_rdy = 0;
    check("R12 w1c", int'(irq_rdy_o), 0);
    check("R4 kept bytes", int'(len_o), 2);
    // last pop and clear in same cycle
    pop = 1; tick(); pop = 1; ctl_we = 1; ctl_clr = 1; tick();
    pop = 0; ctl_we = 0; ctl_clr = 0;
    check("R3 pop+clear", int'(valid_o), 0);

    // R13 direction change flushes
    sie_rx(3, 8'h60, 1);
    clr_rdy = 1; dir = 1; tick(); clr_rdy = 0;
    tick();
    check("R13 flush valid", int'(valid_o), 0);
    check("R13 flush len", int'(len_o), 0);
    check("R13 no irq", int'({irq_rdy_o, irq_emp_o}), 0);

    // R5 full packet, R9 transmit
    cpu_push(8, 8'h80);
    check("R5 full valid", int'(valid_o), 1);
    check("R5 not short", int'(tx_short_o), 0);
    cpu_push(2, 8'hA0);
    check("R5 push ignored", int'(len_o), 8);
    tx_start = 1; tick(); tx_start = 0;
    sie_tx(3, 0);
    check("R9 third byte", int'(rdata_o), 8'h83);
    tx_start = 1; tick(); tx_start = 0;
    check("R9 rewind", int'(rdata_o), 8'h80);
    sie_tx(8, 1);
    check("R9 sent valid", int'(valid_o), 0);
    check("R10 disabled", int'(irq_emp_o), 0);

    // R6 short packet, R10 empty irq
    emp_en = 1;
    cpu_push(3, 8'hC0);
    ctl(1, 0);
    check("R6 valid", int'(valid_o), 1);
    check("R6 short", int'(tx_short_o), 1);
    check("R6 len", int'(len_o), 3);
    sie_tx(3, 1);
    check("R10 emp set", int'(irq_emp_o), 1);
    clr_emp = 1; tick(); clr_emp = 0;

    // R6 zero-length, R8 clear with valid 1
    ctl(1, 0);
    check("R6 zlp", int'(tx_zlp_o), 1);
    ctl(0, 1);
    check("R8 sie clear", int'(valid_o), 0);
    check("R10 emp on clear", int'(irq_emp_o), 1);

    // R7 set+clear gives zlp after flush
    cpu_push(4, 8'hD0);
    ctl(1, 1);
    check("R7 valid", int'(valid_o), 1);
    check("R7 len", int'(len_o), 0);
    check("R7 zlp", int'(tx_zlp_o), 1);
    tick(3);
    check("R7 held", int'(valid_o), 1);
    sie_tx(0, 1);
    check("R7 sent", int'(valid_o), 0);

    // R8 clear with valid 0
    cpu_push(2, 8'hE0);
    ctl(0, 1);
    check("R8 cpu clear len", int'(len_o), 0);
    check("R8 cpu clear valid", int'(valid_o), 0);

    // R11 request pending blocks control writes
    cpu_push(2, 8'hF0);
    req = 1;
    ctl(1, 0);
    check("R11 set blocked", int'(valid_o), 0);
    ctl(0, 1);
    check("R11 clear blocked", int'(len_o), 2);
    req = 0;
    // R5 push ignored during control write
    push = 1; wdata = 8'h77; ctl_we = 1; ctl_set = 1; tick();
    push = 0; ctl_we = 0; ctl_set = 0;
    check("R5 push in ctl cycle", int'(len_o), 2);
    sie_tx(2, 1);
    tick(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule